// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block sits between a synchronous host and an external asynchronous static RAM of 512K words by 24 bits. The memory is split into three 8-bit lanes, and each lane has its own active-low chip enable. The host hands over one request at a time through a valid/ready handshake. A request carries a word address, write data, a lane mask and a direction flag. The controller plays out the matching sequence on the memory's address, lane-enable, write-enable and output-enable pins. It steers a tri-state data bus, which is given as a split output value, a per-lane drive enable and an input value. For reads it returns the captured word with a one-cycle valid strobe.

All memory timing is held as whole clock counts. These counts are derived at elaboration by rounding the nanosecond limits up against the clock-period parameter, and no count is ever below one. Output enable is forced high for every write. The controller's own data drivers switch on only after one clock in which the lanes are selected and the memory is already told to stop driving. A request with an empty lane mask is retired in the cycle it is accepted, and no memory pin moves.

Top module: `sram_lane_ctrl`

## Requirements
- R1: `reqReady` is high only while the controller is idle, and a request is taken on a rising edge where `reqValid` and `reqReady` are both high. With the default timing, `reqReady` returns three cycles after a non-empty write or read is taken.
- R2: Mask bit i selects lane i, which is data bits 8i+7 down to 8i. While the memory is being accessed, `memCeN[i]` is low exactly for the lanes whose mask bit is set.
- R3: A write first spends a setup stretch with the lanes selected, WE high and the drivers off. This stretch lasts ceil(turnaround/period) clocks, which is one clock by default. WE is then low for max(ceil(pulse/period), ceil(data setup/period)) clocks, which is one clock at 8 ns. During that pulse the drivers are on for exactly the masked lanes. One hold clock follows with WE high and the drivers still on. Only masked lanes of the stored word change.
- R4: OE stays high for the whole of a write. The data drivers are never on while OE is low. The drivers are off in the first cycle after a write is taken.
- R5: A read holds OE low, WE high and the masked lanes selected for max(ceil(read cycle/period), ceil(address access/period), ceil(OE access/period)) clocks, which is two clocks at 8 ns.
- R6: Read data is captured at the end of the access. `rdValid` is high for one cycle, in the cycle after OE rises, and at that point `rdData` holds the stored lanes selected by the mask, with zero in the unselected lanes.
- R7: A request with mask 3'b000 is taken and retired at once. `reqReady` stays high, and no lane enable, WE or OE pin changes. For a read, `rdValid` pulses in the following cycle with `rdData` equal to zero.
- R8: `memAddr` takes the request address on acceptance and holds it stable while any lane is selected.
- R9: In reset, `reqReady` is high, all lane enables, WE and OE are high, the drivers are off and `rdValid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Host request present |
| reqReady | output | 1 | Controller idle and able to take a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 19 | Word address |
| reqWdata | input | 24 | Write data |
| reqMask | input | 3 | Lane mask, bit i for data bits 8i+7:8i |
| rdValid | output | 1 | One-cycle read-data strobe |
| rdData | output | 24 | Captured read word |
| memAddr | output | 19 | Memory address |
| memCeN | output | 3 | Per-lane chip enables, active low |
| memWeN | output | 1 | Write enable, active low |
| memOeN | output | 1 | Output enable, active low |
| memDqOut | output | 24 | Value driven onto the data bus |
| memDqOe | output | 3 | Per-lane driver enable for the data bus |
| memDqIn | input | 24 | Value sampled from the data bus |

## Verification
Every pin is registered. So with a request taken at edge k, the setup, pulse, hold and access phases occupy fixed cycle slots after k. A write returns `reqReady` at k+3, and a read raises `rdValid` at k+2 and returns `reqReady` at k+3. The bench samples once per cycle at the falling edge, starting from the first falling edge after acceptance. It indexes each sample from zero and compares the indices at which WE falls, OE stays low, `rdValid` appears and `reqReady` returns against counts it derives from the nanosecond limits and the 8 ns period. An empty-mask request must show `reqReady` and the `rdValid` pulse already at index zero.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSET,
    ST_WPUL,
    ST_WHLD,
    ST_RACC,
    ST_RDONE
  } ctlState_t;

  typedef struct packed {
    logic latch;      // take request into datapath
    logic capture;    // sample read bus at end of access
    logic zeroRd;     // empty-mask read retires
    logic selNext;    // lane enables active next cycle
    logic weLowNext;  // write enable low next cycle
    logic oeLowNext;  // output enable low next cycle
    logic driveNext;  // data drivers on next cycle
  } ctlStrobe_t;

  function automatic int ceilCycles(input int ps, input int clkPs);
    int c;
    c = (ps + clkPs - 1) / clkPs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int TURN_CYC = 1,
  parameter int WP_CYC   = 1,
  parameter int ACC_CYC  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic       reqMaskZero,
  output logic       reqReady,
  output ctlStrobe_t strobe
);

  localparam int MAX_CYC = maxOf(maxOf(TURN_CYC, WP_CYC), ACC_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  ctlState_t state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;

  assign reqReady = (state == ST_IDLE);

  always_comb begin
    stateNext      = state;
    cntNext        = cnt;
    strobe.latch   = 1'b0;
    strobe.capture = 1'b0;
    strobe.zeroRd  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          if (reqMaskZero) begin
            strobe.zeroRd = !reqWrite;
          end else if (reqWrite) begin
            strobe.latch = 1'b1;
            stateNext    = ST_WSET;
            cntNext      = CNT_W'(TURN_CYC - 1);
          end else begin
            strobe.latch = 1'b1;
            stateNext    = ST_RACC;
            cntNext      = CNT_W'(ACC_CYC - 1);
          end
        end
      end
      ST_WSET: begin
        if (cnt == '0) begin
          stateNext = ST_WPUL;
          cntNext   = CNT_W'(WP_CYC - 1);
        end else begin
          cntNext = cnt - 1'b1;
        end
      end
      ST_WPUL: begin
        if (cnt == '0) stateNext = ST_WHLD;
        else           cntNext   = cnt - 1'b1;
      end
      ST_WHLD: stateNext = ST_IDLE;
      ST_RACC: begin
        if (cnt == '0) begin
          stateNext      = ST_RDONE;
          strobe.capture = 1'b1;
        end else begin
          cntNext = cnt - 1'b1;
        end
      end
      ST_RDONE: stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
    strobe.selNext   = (stateNext == ST_WSET) || (stateNext == ST_WPUL) ||
                       (stateNext == ST_WHLD) || (stateNext == ST_RACC);
    strobe.weLowNext = (stateNext == ST_WPUL);
    strobe.oeLowNext = (stateNext == ST_RACC);
    strobe.driveNext = (stateNext == ST_WPUL) || (stateNext == ST_WHLD);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
    end
  end

endmodule

// File: rtl/sram_lane_dp.sv
module sram_lane_dp
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int LANE_W = 8,
  parameter int LANES  = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctlStrobe_t                strobe,
  input  logic [ADDR_W-1:0]         reqAddr,
  input  logic [LANE_W*LANES-1:0]   reqWdata,
  input  logic [LANES-1:0]          reqMask,
  output logic [ADDR_W-1:0]         memAddr,
  output logic [LANES-1:0]          memCeN,
  output logic                      memWeN,
  output logic                      memOeN,
  output logic [LANE_W*LANES-1:0]   memDqOut,
  output logic [LANES-1:0]          memDqOe,
  input  logic [LANE_W*LANES-1:0]   memDqIn,
  output logic                      rdValid,
  output logic [LANE_W*LANES-1:0]   rdData
);

  localparam int DATA_W = LANE_W * LANES;

  logic [LANES-1:0]  maskQ;
  logic [LANES-1:0]  laneSel;
  logic [DATA_W-1:0] wdataQ;

  always_comb laneSel = strobe.latch ? reqMask : maskQ;

  assign memDqOut = wdataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr <= '0;
      memCeN  <= '1;
      memWeN  <= 1'b1;
      memOeN  <= 1'b1;
      memDqOe <= '0;
      maskQ   <= '0;
      wdataQ  <= '0;
      rdValid <= 1'b0;
    end else begin
      if (strobe.latch) begin
        memAddr <= reqAddr;
        maskQ   <= reqMask;
        wdataQ  <= reqWdata;
      end
      memCeN  <= strobe.selNext ? ~laneSel : '1;
      memWeN  <= !strobe.weLowNext;
      memOeN  <= !strobe.oeLowNext;
      memDqOe <= strobe.driveNext ? laneSel : '0;
      rdValid <= strobe.capture | strobe.zeroRd;
    end
  end

  for (genvar lane = 0; lane < LANES; lane++) begin : gLane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rdData[lane*LANE_W +: LANE_W] <= '0;
      end else if (strobe.zeroRd) begin
        rdData[lane*LANE_W +: LANE_W] <= '0;
      end else if (strobe.capture) begin
        rdData[lane*LANE_W +: LANE_W] <= maskQ[lane] ? memDqIn[lane*LANE_W +: LANE_W] : '0;
      end
    end
  end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W  = 19,
  parameter int LANE_W  = 8,
  parameter int LANES   = 3,
  parameter int CLK_PS  = 8000,
  parameter int TURN_PS = 5000,
  parameter int WP_PS   = 8000,
  parameter int DS_PS   = 6000,
  parameter int RC_PS   = 10000,
  parameter int AA_PS   = 10000,
  parameter int DOE_PS  = 7000
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqValid,
  output logic                      reqReady,
  input  logic                      reqWrite,
  input  logic [ADDR_W-1:0]         reqAddr,
  input  logic [LANE_W*LANES-1:0]   reqWdata,
  input  logic [LANES-1:0]          reqMask,
  output logic                      rdValid,
  output logic [LANE_W*LANES-1:0]   rdData,
  output logic [ADDR_W-1:0]         memAddr,
  output logic [LANES-1:0]          memCeN,
  output logic                      memWeN,
  output logic                      memOeN,
  output logic [LANE_W*LANES-1:0]   memDqOut,
  output logic [LANES-1:0]          memDqOe,
  input  logic [LANE_W*LANES-1:0]   memDqIn
);

  localparam int TURN_CYC = ceilCycles(TURN_PS, CLK_PS);
  localparam int WP_CYC   = maxOf(ceilCycles(WP_PS, CLK_PS), ceilCycles(DS_PS, CLK_PS));
  localparam int ACC_CYC  = maxOf(maxOf(ceilCycles(RC_PS, CLK_PS), ceilCycles(AA_PS, CLK_PS)),
                                  ceilCycles(DOE_PS, CLK_PS));

  ctlStrobe_t strobe;
  logic       reqMaskZero;

  assign reqMaskZero = (reqMask == '0);

  sram_ctl_fsm #(
    .TURN_CYC(TURN_CYC),
    .WP_CYC  (WP_CYC),
    .ACC_CYC (ACC_CYC)
  ) uCtl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .reqMaskZero(reqMaskZero),
    .reqReady   (reqReady),
    .strobe     (strobe)
  );

  sram_lane_dp #(
    .ADDR_W(ADDR_W),
    .LANE_W(LANE_W),
    .LANES (LANES)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .reqMask (reqMask),
    .memAddr (memAddr),
    .memCeN  (memCeN),
    .memWeN  (memWeN),
    .memOeN  (memOeN),
    .memDqOut(memDqOut),
    .memDqOe (memDqOe),
    .memDqIn (memDqIn),
    .rdValid (rdValid),
    .rdData  (rdData)
  );

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
  parameter int ADDR_W = 19,
  parameter int LANES  = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              rdValid,
  input logic [ADDR_W-1:0] memAddr,
  input logic [LANES-1:0]  memCeN,
  input logic              memWeN,
  input logic              memOeN,
  input logic [LANES-1:0]  memDqOe
);

  // R4
  oe_high_in_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> memOeN);

  // R4
  no_drive_with_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memDqOe != '0) |-> memOeN);

  // R4
  drive_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memDqOe != '0) |-> ($past(memCeN) == memCeN));

  // R3
  pulse_lanes_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (memDqOe == ~memCeN));

  // R1
  idle_pins_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memCeN == '1 && memWeN && memOeN && memDqOe == '0));

  // R6
  valid_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> memOeN);

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memCeN != '1 && $past(memCeN) != '1) |-> $stable(memAddr));

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
  .ADDR_W(ADDR_W),
  .LANES (LANES)
) chkInst (
  .clk     (clk),
  .rstN    (rstN),
  .reqReady(reqReady),
  .rdValid (rdValid),
  .memAddr (memAddr),
  .memCeN  (memCeN),
  .memWeN  (memWeN),
  .memOeN  (memOeN),
  .memDqOe (memDqOe)
);

// File: tb/tb_sram_lane_ctrl.sv
`timescale 1ns/1ps
module tb_sram_lane_ctrl;

  localparam int CLK_PS = 8000;

  function automatic int cdiv(input int a, input int b);
    int c;
    c = (a + b - 1) / b;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int TURN = cdiv(5000, CLK_PS);
  localparam int WP   = mx(cdiv(8000, CLK_PS), cdiv(6000, CLK_PS));
  localparam int ACC  = mx(mx(cdiv(10000, CLK_PS), cdiv(10000, CLK_PS)), cdiv(7000, CLK_PS));

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [18:0] reqAddr = '0;
  logic [23:0] reqWdata = '0;
  logic [2:0]  reqMask = '0;
  logic        rdValid;
  logic [23:0] rdData;
  logic [18:0] memAddr;
  logic [2:0]  memCeN;
  logic        memWeN;
  logic        memOeN;
  logic [23:0] memDqOut;
  logic [2:0]  memDqOe;
  logic [23:0] memDqIn;

  int checks = 0;
  int errors = 0;
  int contention = 0;
  bit done = 1'b0;

  logic [23:0] memModel [int];
  logic [23:0] shadow [int];

  always #4 clk = ~clk;

  sram_lane_ctrl dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask),
    .rdValid(rdValid), .rdData(rdData), .memAddr(memAddr), .memCeN(memCeN),
    .memWeN(memWeN), .memOeN(memOeN), .memDqOut(memDqOut), .memDqOe(memDqOe),
    .memDqIn(memDqIn)
  );

  // Memory model: write lanes on the rising edge of write enable
  always @(posedge memWeN) begin
    if (rstN === 1'b1) begin
      logic [23:0] w;
      w = memModel.exists(int'(memAddr)) ? memModel[int'(memAddr)] : 24'h0;
      for (int l = 0; l < 3; l++)
        if (memCeN[l] === 1'b0 && memDqOe[l] === 1'b1) w[l*8 +: 8] = memDqOut[l*8 +: 8];
      memModel[int'(memAddr)] = w;
    end
  end

  // Read path: unselected lanes return junk so the controller must mask them
  always @(memAddr or memCeN or memWeN or memOeN or posedge memWeN) begin
    logic [23:0] r;
    r = memModel.exists(int'(memAddr)) ? memModel[int'(memAddr)] : 24'h0;
    for (int l = 0; l < 3; l++)
      memDqIn[l*8 +: 8] = (memCeN[l] === 1'b0 && memWeN === 1'b1 && memOeN === 1'b0)
                          ? r[l*8 +: 8] : 8'hA5;
  end

  always @(negedge clk) begin
    if (rstN === 1'b1 && memOeN === 1'b0 && memWeN === 1'b1)
      for (int l = 0; l < 3; l++)
        if (memDqOe[l] === 1'b1 && memCeN[l] === 1'b0) contention++;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] expectWord(input logic [18:0] a, input logic [2:0] m);
    logic [23:0] v;
    logic [23:0] o;
    v = shadow.exists(int'(a)) ? shadow[int'(a)] : 24'h0;
    o = '0;
    for (int l = 0; l < 3; l++) if (m[l]) o[l*8 +: 8] = v[l*8 +: 8];
    return o;
  endfunction

  task automatic runReq(input bit wr, input logic [18:0] a, input logic [23:0] d, input logic [2:0] m);
    int readyIdx = -1, weLow = 0, weFirst = -1, oeLow = 0, validIdx = -1;
    logic [23:0] got = '0;
    bit ceBad = 0, addrBad = 0, oeBad = 0, weBad = 0, dqBad = 0, dq0Bad = 0, toggled = 0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d; reqMask = m;
    @(posedge clk);
    for (int idx = 0; idx < 20; idx++) begin
      @(negedge clk);
      if (idx == 0) reqValid = 1'b0;
      if (rdValid && validIdx < 0) begin validIdx = idx; got = rdData; end
      if (!memWeN) begin
        if (weFirst < 0) weFirst = idx;
        weLow++;
        if (memDqOe != m) dqBad = 1;
        if (memCeN != ~m) ceBad = 1;
      end
      if (!memOeN) begin
        oeLow++;
        if (memCeN != ~m) ceBad = 1;
        if (!memWeN) weBad = 1;
        if (wr) oeBad = 1;
      end
      if (memCeN != 3'b111 && memAddr != a) addrBad = 1;
      if (idx == 0 && memDqOe != 3'b000) dq0Bad = 1;
      if (memCeN != 3'b111 || !memWeN || !memOeN) toggled = 1;
      if (reqReady) begin readyIdx = idx; break; end
    end
    if (m == 3'b000) begin
      chk(readyIdx == 0, "R7 empty mask retires at once", readyIdx, 0);
      chk(!toggled, "R7 empty mask moves no pin", toggled, 0);
      if (!wr) begin
        chk(validIdx == 0, "R7 empty-mask read valid slot", validIdx, 0);
        chk(got == 24'h0, "R7 empty-mask read data", got, 0);
      end
    end else if (wr) begin
      chk(readyIdx == TURN + WP + 1, "R1 ready return after write", readyIdx, TURN + WP + 1);
      chk(weLow == WP, "R3 WE pulse cycles", weLow, WP);
      chk(weFirst == TURN, "R3 setup before WE low", weFirst, TURN);
      chk(!dq0Bad, "R4 drivers off after accept", dq0Bad, 0);
      chk(!oeBad, "R4 OE high in write", oeBad, 0);
      chk(!dqBad, "R3 driven lanes match mask", dqBad, 0);
      chk(!ceBad, "R2 lane enables in write", ceBad, 0);
      chk(!addrBad, "R8 address during write", addrBad, 0);
      begin
        logic [23:0] v;
        v = shadow.exists(int'(a)) ? shadow[int'(a)] : 24'h0;
        for (int l = 0; l < 3; l++) if (m[l]) v[l*8 +: 8] = d[l*8 +: 8];
        shadow[int'(a)] = v;
      end
    end else begin
      chk(readyIdx == ACC + 1, "R1 ready return after read", readyIdx, ACC + 1);
      chk(oeLow == ACC, "R5 OE low cycles", oeLow, ACC);
      chk(!weBad, "R5 WE high in read", weBad, 0);
      chk(!ceBad, "R2 lane enables in read", ceBad, 0);
      chk(!addrBad, "R8 address during read", addrBad, 0);
      chk(validIdx == ACC, "R6 valid slot", validIdx, ACC);
      chk(got == expectWord(a, m), "R6 read data", got, expectWord(a, m));
    end
  endtask

  initial begin
    logic [18:0] addrs [5];
    addrs[0] = 19'h00000; addrs[1] = 19'h7FFFF; addrs[2] = 19'h2AAAA;
    addrs[3] = 19'h55555; addrs[4] = 19'h00001;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk(reqReady === 1'b1, "R9 ready in reset", reqReady, 1);
    chk(memCeN === 3'b111, "R9 lane enables in reset", memCeN, 3'b111);
    chk(memWeN === 1'b1 && memOeN === 1'b1, "R9 WE/OE in reset", {memWeN, memOeN}, 2'b11);
    chk(memDqOe === 3'b000 && rdValid === 1'b0, "R9 drivers and valid in reset",
        {memDqOe, rdValid}, 0);
    rstN = 1'b1;
    for (int ai = 0; ai < 5; ai++) begin
      runReq(1'b1, addrs[ai], 24'(addrs[ai] * 13) ^ 24'hC3A55A, 3'b111);
      runReq(1'b0, addrs[ai], 24'h0, 3'b111);
      for (int m = 1; m < 7; m++) begin
        runReq(1'b1, addrs[ai], 24'(addrs[ai] * 7 + m * 24'h10305) ^ 24'h5A3C96, 3'(m));
        runReq(1'b0, addrs[ai], 24'h0, 3'b111);
        runReq(1'b0, addrs[ai], 24'h0, 3'(m));
      end
    end
    // R7 empty masks leave memory untouched
    runReq(1'b1, addrs[2], 24'hFFFFFF, 3'b000);
    runReq(1'b0, addrs[2], 24'h0, 3'b000);
    runReq(1'b0, addrs[2], 24'h0, 3'b111);
    chk(contention == 0, "R4 bus contention", contention, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 100000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule